// File: doc/BRIEF.md
# SCSI Target Bus Phase Sequencer

This block is the target-side state machine for a parallel SCSI bus. It watches the lines the initiator drives (SEL, ACK, RST, the data bus and a qualifier saying the initiator is driving that bus). From them it tracks the bus through free, arbitration, selection and the information-transfer phases. It drives the target's MSG, C/D, I/O, BSY and REQ lines. It answers each ACK with a REQ/ACK handshake, and it reports the selected target ID.

A separate command decoder chooses what follows the command and data phases. It does this by offering completion events on a valid/ready channel. An event is taken on a clock edge where both `evt_valid` and `evt_ready` are high. `evt_ready` is high only in the command, data-out and data-in phases, and only while bus reset is low. Outside those phases an offered event waits, with no effect, until it is withdrawn or becomes acceptable.

The transaction ends without further decoder help. The target sends the status byte, then a single zero message byte, then releases the bus. Each entry into an information phase raises a one-cycle interrupt pulse.

Top module: `scsi_tgt_seq`

## Requirements
- R1: `phase_o` uses the codes free 0, arbitration 1, selection 2, reselection 3, command 4, data out 5, data in 6, status 7, message in 8, message out 9. The lines {MSG, C/D, I/O} read 010 in command, 000 in data out, 001 in data in, 011 in status, 111 in message in, 110 in message out, and 000 in free, arbitration and selection. After reset the phase is free and BSY, REQ and `irq` are low.
- R2: In free, `arb_req` high moves the phase to arbitration at the next edge. In free or arbitration, SEL high with the data-bus qualifier high and a nonzero data bus moves the phase to selection at the next edge. At the same edge, `tgt_id` becomes the index of the lowest set data bit and BSY rises.
- R3: A selection attempt whose data bus is all zero is ignored: the phase and BSY stay unchanged.
- R4: When SEL goes low during selection, the next edge enters command with REQ high.
- R5: In the command, data, status and message-in phases, REQ at each edge takes the inverse of ACK sampled at that edge. The exceptions are the two transitions named in R7 and R8.
- R6: An accepted event of kind 1 enters data in, kind 2 enters data out, and kind 3 enters status and latches `evt_status` as the status byte. Kind 0 does nothing. The change takes effect at the accepting edge.
- R7: In status, `db_out` carries the latched status byte. Once ACK has been high in status, ACK low while REQ is low enters message in with REQ high, and `db_out` becomes 0x00.
- R8: In message in, ACK low while REQ is low enters free at the next edge, with BSY, REQ, MSG, C/D and I/O all low.
- R9: `irq` is high for exactly the first cycle of each entry into command, data out, data in, status or message in. It stays low on entry into free, arbitration or selection.
- R10: While `bus_rst` is high, BSY, REQ, MSG, C/D and I/O are low in the same cycle, and the phase becomes free at the next edge.
- R11: While `evt_ready` is low (for example in status), an offered event leaves the phase unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rst | input | 1 | RST line of the bus |
| arb_req | input | 1 | Initiator is arbitrating |
| sel | input | 1 | SEL line |
| ack | input | 1 | ACK line |
| drive_data | input | 1 | Initiator asserts the data bus |
| db_in | input | DW | Data bus as driven by the initiator |
| evt_valid | input | 1 | Decoder event offered |
| evt_ready | output | 1 | Event can be taken this cycle |
| evt_kind | input | 2 | 0 none, 1 data in, 2 data out, 3 status |
| evt_status | input | DW | Status byte carried by a kind-3 event |
| tgt_msg | output | 1 | MSG line |
| tgt_cd | output | 1 | C/D line |
| tgt_io | output | 1 | I/O line |
| tgt_bsy | output | 1 | BSY line driven by the target |
| tgt_req | output | 1 | REQ line |
| db_out | output | DW | Byte the target presents in status and message in |
| tgt_id | output | IDW | Selected target ID |
| phase_o | output | 4 | Current phase code |
| irq | output | 1 | Phase-entry interrupt pulse |

## Verification
Two selections are made. The first goes through arbitration with data 0x28, after a zero-data attempt. The second starts straight from free with data 0x81, whose low and high bits are both set, so the lowest-bit rule is told apart from a highest-bit one. The first transaction runs the full path: command, data in, status and message in back to free. That pins down which ACK edge ends status and which ends message in. The second is cut off by bus reset during data out, which shows that the line release is combinational and the phase return is registered. An event offered during status checks that the ready rule blocks it.

// File: rtl/scsi_tgt_pkg.sv
package scsi_tgt_pkg;

  typedef enum logic [3:0] {
    PH_FREE  = 4'd0,
    PH_ARB   = 4'd1,
    PH_SEL   = 4'd2,
    PH_RESEL = 4'd3,
    PH_CMD   = 4'd4,
    PH_DOUT  = 4'd5,
    PH_DIN   = 4'd6,
    PH_STAT  = 4'd7,
    PH_MIN   = 4'd8,
    PH_MOUT  = 4'd9
  } phase_e;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_DIN  = 2'd1,
    EV_DOUT = 2'd2,
    EV_STAT = 2'd3
  } evt_e;

  // {MSG, C/D, I/O} for each phase
  function automatic logic [2:0] phase_lines(phase_e p);
    case (p)
      PH_CMD:  return 3'b010;
      PH_DIN:  return 3'b001;
      PH_STAT: return 3'b011;
      PH_MIN:  return 3'b111;
      PH_MOUT: return 3'b110;
      default: return 3'b000;
    endcase
  endfunction

  // information-transfer phases: REQ/ACK handshake active, entry interrupts
  function automatic logic is_xfer(phase_e p);
    return (p == PH_CMD) || (p == PH_DOUT) || (p == PH_DIN) ||
           (p == PH_STAT) || (p == PH_MIN) || (p == PH_MOUT);
  endfunction

endpackage

// File: rtl/scsi_sel_detect.sv
module scsi_sel_detect #(
  parameter int DW  = 8,
  parameter int IDW = $clog2(DW)
) (
  input  logic           sel,
  input  logic           drive_data,
  input  logic [DW-1:0]  db,
  output logic           hit,
  output logic [IDW-1:0] id
);
  // lowest set bit wins: scan downward so the last match is the lowest
  always_comb begin
    id = '0;
    for (int i = DW - 1; i >= 0; i--) begin
      if (db[i]) id = IDW'(i);
    end
  end

  assign hit = sel && drive_data && (|db);
endmodule

// File: rtl/scsi_phase_fsm.sv
module scsi_phase_fsm
  import scsi_tgt_pkg::*;
#(
  parameter int DW  = 8,
  parameter int IDW = $clog2(DW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_rst,
  input  logic           arb_req,
  input  logic           sel,
  input  logic           ack,
  input  logic           sel_hit,
  input  logic [IDW-1:0] sel_id,
  input  logic           evt_valid,
  input  logic [1:0]     evt_kind,
  input  logic [DW-1:0]  evt_status,
  output logic           evt_ready,
  output phase_e         phase_q,
  output logic           req_q,
  output logic           bsy_q,
  output logic [IDW-1:0] id_q,
  output logic [DW-1:0]  stat_q
);
  phase_e         ph_d;
  logic           req_d, bsy_d, seen_q, seen_d;
  logic [IDW-1:0] id_d;
  logic [DW-1:0]  stat_d;
  logic           evt_take;

  assign evt_ready = !bus_rst &&
                     ((phase_q == PH_CMD) || (phase_q == PH_DIN) || (phase_q == PH_DOUT));
  assign evt_take  = evt_valid && evt_ready;

  always_comb begin
    ph_d   = phase_q;
    req_d  = req_q;
    bsy_d  = bsy_q;
    seen_d = seen_q;
    id_d   = id_q;
    stat_d = stat_q;
    if (is_xfer(phase_q)) req_d = !ack;
    case (phase_q)
      PH_FREE, PH_ARB: begin
        if (sel_hit) begin
          ph_d  = PH_SEL;
          bsy_d = 1'b1;
          id_d  = sel_id;
          req_d = 1'b0;
        end else if (phase_q == PH_FREE && arb_req) begin
          ph_d = PH_ARB;
        end else if (phase_q == PH_ARB && !arb_req) begin
          ph_d = PH_FREE;
        end
      end
      PH_SEL: begin
        if (!sel) begin
          ph_d  = PH_CMD;
          req_d = 1'b1;
        end
      end
      PH_CMD, PH_DIN, PH_DOUT: begin
        if (evt_take) begin
          case (evt_e'(evt_kind))
            EV_DIN:  ph_d = PH_DIN;
            EV_DOUT: ph_d = PH_DOUT;
            EV_STAT: begin
              ph_d   = PH_STAT;
              stat_d = evt_status;
              seen_d = 1'b0;
            end
            default: ;
          endcase
        end
      end
      PH_STAT: begin
        if (ack) seen_d = 1'b1;
        if (seen_q && !ack && !req_q) begin
          ph_d  = PH_MIN;
          req_d = 1'b1;
        end
      end
      PH_MIN: begin
        if (!ack && !req_q) begin
          ph_d  = PH_FREE;
          req_d = 1'b0;
          bsy_d = 1'b0;
        end
      end
      default: ;
    endcase
    if (bus_rst) begin
      ph_d   = PH_FREE;
      req_d  = 1'b0;
      bsy_d  = 1'b0;
      seen_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_FREE;
      req_q   <= 1'b0;
      bsy_q   <= 1'b0;
      seen_q  <= 1'b0;
      id_q    <= '0;
      stat_q  <= '0;
    end else begin
      phase_q <= ph_d;
      req_q   <= req_d;
      bsy_q   <= bsy_d;
      seen_q  <= seen_d;
      id_q    <= id_d;
      stat_q  <= stat_d;
    end
  end

  a_r2_sel_has_bsy: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SEL) |-> bsy_q);

  a_r4_sel_release: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SEL && !sel && !bus_rst) |=> (phase_q == PH_CMD && req_q));

  a_r5_req_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_CMD || phase_q == PH_DIN || phase_q == PH_DOUT) && !bus_rst)
      |=> (req_q == !$past(ack)));

  a_r8_msg_to_free: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_MIN && !ack && !req_q) |=> (phase_q == PH_FREE && !bsy_q));

  a_r10_bus_reset: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (phase_q == PH_FREE && !bsy_q && !req_q));
endmodule

// File: rtl/scsi_line_drive.sv
module scsi_line_drive
  import scsi_tgt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_rst,
  input  phase_e        phase_q,
  input  logic          req_q,
  input  logic          bsy_q,
  input  logic [DW-1:0] stat_q,
  output logic          msg,
  output logic          cd,
  output logic          io,
  output logic          bsy,
  output logic          req,
  output logic [DW-1:0] db_out,
  output logic          irq
);
  phase_e     prev_q;
  logic [2:0] lines;

  assign lines          = phase_lines(phase_q);
  assign {msg, cd, io}  = bus_rst ? 3'b000 : lines;
  assign bsy            = bsy_q && !bus_rst;
  assign req            = req_q && !bus_rst;
  assign db_out         = (phase_q == PH_STAT) ? stat_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= PH_FREE;
    else        prev_q <= phase_q;
  end

  assign irq = (phase_q != prev_q) && is_xfer(phase_q);

  a_r9_no_irq_free: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_FREE || phase_q == PH_ARB || phase_q == PH_SEL) |-> !irq);

  a_r1_msg_lines: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg) |-> (cd && io));
endmodule

// File: rtl/scsi_tgt_seq.sv
module scsi_tgt_seq
  import scsi_tgt_pkg::*;
#(
  parameter int DW  = 8,
  parameter int IDW = $clog2(DW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_rst,
  input  logic           arb_req,
  input  logic           sel,
  input  logic           ack,
  input  logic           drive_data,
  input  logic [DW-1:0]  db_in,
  input  logic           evt_valid,
  output logic           evt_ready,
  input  logic [1:0]     evt_kind,
  input  logic [DW-1:0]  evt_status,
  output logic           tgt_msg,
  output logic           tgt_cd,
  output logic           tgt_io,
  output logic           tgt_bsy,
  output logic           tgt_req,
  output logic [DW-1:0]  db_out,
  output logic [IDW-1:0] tgt_id,
  output logic [3:0]     phase_o,
  output logic           irq
);
  logic           sel_hit;
  logic [IDW-1:0] sel_id;
  phase_e         phase_q;
  logic           req_q, bsy_q;
  logic [DW-1:0]  stat_q;

  scsi_sel_detect #(.DW(DW), .IDW(IDW)) u_sel (
    .sel(sel), .drive_data(drive_data), .db(db_in), .hit(sel_hit), .id(sel_id)
  );

  scsi_phase_fsm #(.DW(DW), .IDW(IDW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .arb_req(arb_req),
    .sel(sel), .ack(ack), .sel_hit(sel_hit), .sel_id(sel_id),
    .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_status(evt_status),
    .evt_ready(evt_ready), .phase_q(phase_q), .req_q(req_q), .bsy_q(bsy_q),
    .id_q(tgt_id), .stat_q(stat_q)
  );

  scsi_line_drive #(.DW(DW)) u_drv (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .phase_q(phase_q),
    .req_q(req_q), .bsy_q(bsy_q), .stat_q(stat_q),
    .msg(tgt_msg), .cd(tgt_cd), .io(tgt_io), .bsy(tgt_bsy), .req(tgt_req),
    .db_out(db_out), .irq(irq)
  );

  assign phase_o = phase_q;
endmodule

// File: tb/sim_scsi_tgt_seq.sv
module sim_scsi_tgt_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_rst = 1'b0, arb_req = 1'b0, sel = 1'b0, ack = 1'b0, drive_data = 1'b0;
  logic [7:0] db_in = 8'h00, evt_status = 8'h00;
  logic       evt_valid = 1'b0;
  logic [1:0] evt_kind = 2'd0;
  logic       evt_ready, tgt_msg, tgt_cd, tgt_io, tgt_bsy, tgt_req, irq;
  logic [7:0] db_out;
  logic [2:0] tgt_id;
  logic [3:0] phase_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [3:0] exp_q[$];
  logic [3:0] last_ph = 4'd0;

  always #5 clk = ~clk;

  scsi_tgt_seq u0 (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .arb_req(arb_req), .sel(sel),
    .ack(ack), .drive_data(drive_data), .db_in(db_in), .evt_valid(evt_valid),
    .evt_ready(evt_ready), .evt_kind(evt_kind), .evt_status(evt_status),
    .tgt_msg(tgt_msg), .tgt_cd(tgt_cd), .tgt_io(tgt_io), .tgt_bsy(tgt_bsy),
    .tgt_req(tgt_req), .db_out(db_out), .tgt_id(tgt_id), .phase_o(phase_o), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [2:0] want_lines(input logic [3:0] p);
    case (p)
      4'd4: return 3'b010;
      4'd6: return 3'b001;
      4'd7: return 3'b011;
      4'd8: return 3'b111;
      4'd9: return 3'b110;
      default: return 3'b000;
    endcase
  endfunction

  // monitor: every phase change is popped from the scoreboard and compared
  always @(negedge clk) begin
    if (rst_n && !done && phase_o != last_ph) begin
      if (exp_q.size() == 0) begin
        check("R1 unexpected phase change", phase_o, last_ph);
      end else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        check("R1 phase sequence", phase_o, e);
        check("R1 line encoding", {tgt_msg, tgt_cd, tgt_io}, want_lines(e));
        check("R9 entry pulse", irq, (e >= 4'd4 && e <= 4'd8));
      end
      last_ph = phase_o;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    check("R1 reset phase", phase_o, 0);
    check("R1 reset bsy/req/irq", {tgt_bsy, tgt_req, irq}, 0);

    arb_req = 1'b1; exp_q.push_back(4'd1); cyc(1);
    check("R2 arbitration", phase_o, 1);

    sel = 1'b1; drive_data = 1'b1; db_in = 8'h00; cyc(2);
    check("R3 zero data ignored phase", phase_o, 1);
    check("R3 zero data ignored bsy", tgt_bsy, 0);

    db_in = 8'h28; exp_q.push_back(4'd2); cyc(1);
    check("R2 selection phase", phase_o, 2);
    check("R2 lowest bit id", tgt_id, 3);
    check("R2 bsy asserted", tgt_bsy, 1);
    arb_req = 1'b0;

    sel = 1'b0; drive_data = 1'b0; db_in = 8'h00; exp_q.push_back(4'd4); cyc(1);
    check("R4 command req", tgt_req, 1);

    ack = 1'b1; cyc(1);
    check("R5 req low on ack", tgt_req, 0);
    check("R9 pulse one cycle", irq, 0);
    ack = 1'b0; cyc(1);
    check("R5 req high on ack release", tgt_req, 1);

    #1 check("R6 ready in command", evt_ready, 1);
    evt_valid = 1'b1; evt_kind = 2'd1; exp_q.push_back(4'd6); cyc(1);
    evt_valid = 1'b0;
    check("R6 data in entered", phase_o, 6);

    evt_valid = 1'b1; evt_kind = 2'd3; evt_status = 8'hA5; exp_q.push_back(4'd7); cyc(1);
    evt_valid = 1'b0;
    check("R7 status byte out", db_out, 8'hA5);

    evt_valid = 1'b1; evt_kind = 2'd1;
    #1 check("R11 not ready in status", evt_ready, 0);
    cyc(2);
    check("R11 event ignored", phase_o, 7);
    evt_valid = 1'b0;

    ack = 1'b1; cyc(1);
    check("R7 still status while ack", phase_o, 7);
    ack = 1'b0; exp_q.push_back(4'd8); cyc(1);
    check("R7 message in req", tgt_req, 1);
    check("R7 message byte zero", db_out, 0);

    ack = 1'b1; cyc(1);
    check("R5 req low in message in", tgt_req, 0);
    ack = 1'b0; exp_q.push_back(4'd0); cyc(1);
    check("R8 bus free", phase_o, 0);
    check("R8 lines released", {tgt_bsy, tgt_req, tgt_msg, tgt_cd, tgt_io}, 0);

    sel = 1'b1; drive_data = 1'b1; db_in = 8'h81; exp_q.push_back(4'd2); cyc(1);
    check("R2 id from free", tgt_id, 0);
    sel = 1'b0; drive_data = 1'b0; db_in = 8'h00; exp_q.push_back(4'd4); cyc(1);
    evt_valid = 1'b1; evt_kind = 2'd2; exp_q.push_back(4'd5); cyc(1);
    evt_valid = 1'b0;
    check("R6 data out entered", phase_o, 5);
    check("R5 req in data out", tgt_req, 1);

    bus_rst = 1'b1;
    #1 check("R10 lines drop at once", {tgt_bsy, tgt_req}, 0);
    exp_q.push_back(4'd0); cyc(1);
    check("R10 phase free", phase_o, 0);
    bus_rst = 1'b0; cyc(2);
    check("R1 scoreboard drained", exp_q.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule